// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

A memory-mapped watchdog for a system chip. Software programs a reload value, arms the timer and must keep it alive by writing a fixed 16-bit key to a restart word. Writing that key is the only way to put the reload value back into the down-counter. If the counter runs out, the block latches a timeout flag and, when reset-on-expiry is armed, drops its own enable and drives a pulse on a vector of per-peripheral reset lines. The pulse length is programmable.

The count advances either on every clock or only on cycles where an external 1 MHz tick enable is high. A two-bit scope field decides which reset lines the pulse reaches: the lines picked by a 26-bit mask, every line, or the processor line alone. Reads are combinational from a small bank of eight 32-bit words on a plain address/data/write-enable bus.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0, the timeout flag is 0, the reset lines are 0, the reload word and the counter read 0x0000FFFF, the pulse width reads 4 and the mask reads 0x033FFFF3 (bits 0..25 set except 2, 3, 22 and 23).
- R2: A write of exactly 0x00004755 (all 32 bits compared) to word 2 loads the reload value into the counter on that edge; any other value written to word 2 leaves the counter unchanged.
- R3: With control bit 0 set and bit 4 clear the counter drops by one every clock; with bit 4 set it drops only on clocks where tick_1m_en is high; with bit 0 clear it holds.
- R4: When the counter steps while at 1 (or 0) with control bit 1 set, the timeout flag sets, control bit 0 clears and the reset lines go active from the next cycle for max(width,1) cycles, width being bits 7:0 of word 6.
- R5: Control bits 6:5 choose the pulse scope: 0 or 3 drives the lines set in the mask, 1 drives all 26 lines, 2 drives only line 0; mask and scope are captured at expiry.
- R6: Expiry with control bit 1 clear sets the timeout flag, drives no reset line, keeps the enable and reloads the counter, so the flag sets after exactly reload steps.
- R7: A write of any value to word 5 clears the timeout flag.
- R8: Word 0 reads the live counter; word 3 reads back only bits 0, 1, 4, 5, 6 and 7, and bit 7 (a boot marker) changes no behaviour.
- R9: With reload 1, a key write and then control 0x3, the reset pulse starts on the cycle after the first counting edge.
- R10: Words are at fixed word addresses: 0 counter, 1 reload, 2 restart, 3 control, 4 timeout flag (bit 0), 5 flag clear, 6 pulse width, 7 mask (bits 25:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1m_en | input | 1 | Slow count enable, used when control bit 4 is set |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rst_lines | output | 26 | Per-peripheral reset pulse vector |
| expired_flag | output | 1 | Latched timeout flag |

## Verification
The bench sweeps every scope code against pulse widths 0, 1 and 3 and measures start cycle, length and line pattern of each pulse; a design that treats width 0 as no pulse, starts one cycle late or ignores the captured scope shows up there. Near-miss keys (one off, extra high bits) are written to the restart word, which a partial key compare would accept. The tick-gated mode is driven with an irregular tick pattern and the counter is compared each cycle against a running tally, catching a counter that ignores the tick. Periodic expiry without reset checks the exact period, exposing an off-by-one in the expiry test.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 3;
  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT   = 3'd0,
    A_RELOAD  = 3'd1,
    A_RESTART = 3'd2,
    A_CTRL    = 3'd3,
    A_FLAG    = 3'd4,
    A_CLEAR   = 3'd5,
    A_WIDTH   = 3'd6,
    A_MASK    = 3'd7
  } kwd_addr_e;

  typedef enum logic [1:0] {
    SCOPE_MASKED = 2'd0,
    SCOPE_ALL    = 2'd1,
    SCOPE_CPU    = 2'd2,
    SCOPE_MASK_B = 2'd3
  } kwd_scope_e;

  localparam int CB_EN    = 0;
  localparam int CB_RSTEN = 1;
  localparam int CB_SLOW  = 4;
  localparam int CB_SCOPE = 5;
  localparam int CB_BOOT  = 7;
endpackage

// File: rtl/kwd_rst_sync.sv
module kwd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 8,
  parameter int NLINES = 26,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1,
  parameter logic [PW_W-1:0] WIDTH_RST = '0,
  parameter logic [NLINES-1:0] MASK_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              expire,
  output logic              key_hit,
  output logic              clr_hit,
  output logic [CNT_W-1:0]  reload_q,
  output logic              en_q,
  output logic              rsten_q,
  output logic              slow_q,
  output kwd_scope_e        scope_q,
  output logic              boot_q,
  output logic [PW_W-1:0]   width_q,
  output logic [NLINES-1:0] mask_q,
  output logic              flag_q
);
  logic              wr_reload, wr_ctrl, wr_width, wr_mask;
  logic [CNT_W-1:0]  reload_d;
  logic              en_d, rsten_d, slow_d, boot_d, flag_d;
  kwd_scope_e        scope_d;
  logic [PW_W-1:0]   width_d;
  logic [NLINES-1:0] mask_d;

  always_comb begin
    wr_reload = we && (kwd_addr_e'(addr) == A_RELOAD);
    wr_ctrl   = we && (kwd_addr_e'(addr) == A_CTRL);
    wr_width  = we && (kwd_addr_e'(addr) == A_WIDTH);
    wr_mask   = we && (kwd_addr_e'(addr) == A_MASK);
    key_hit   = we && (kwd_addr_e'(addr) == A_RESTART) && (wdata == RESTART_KEY);
    clr_hit   = we && (kwd_addr_e'(addr) == A_CLEAR);
  end

  always_comb begin
    reload_d = wr_reload ? wdata[CNT_W-1:0] : reload_q;
    width_d  = wr_width  ? wdata[PW_W-1:0]  : width_q;
    mask_d   = wr_mask   ? wdata[NLINES-1:0] : mask_q;
    en_d     = en_q;
    rsten_d  = rsten_q;
    slow_d   = slow_q;
    scope_d  = scope_q;
    boot_d   = boot_q;
    if (wr_ctrl) begin
      en_d    = wdata[CB_EN];
      rsten_d = wdata[CB_RSTEN];
      slow_d  = wdata[CB_SLOW];
      scope_d = kwd_scope_e'(wdata[CB_SCOPE+1:CB_SCOPE]);
      boot_d  = wdata[CB_BOOT];
    end
    if (expire && rsten_q) en_d = 1'b0;
    flag_d = flag_q;
    if (clr_hit) flag_d = 1'b0;
    if (expire)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      width_q  <= WIDTH_RST;
      mask_q   <= MASK_RST;
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      slow_q   <= 1'b0;
      scope_q  <= SCOPE_MASKED;
      boot_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      width_q  <= width_d;
      mask_q   <= mask_d;
      en_q     <= en_d;
      rsten_q  <= rsten_d;
      slow_q   <= slow_d;
      scope_q  <= scope_d;
      boot_q   <= boot_d;
      flag_q   <= flag_d;
    end
  end
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             key_hit,
  input  logic             rsten,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_d;
  logic             advance;

  always_comb begin
    advance = en && step && !key_hit;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    if (key_hit) begin
      cnt_d = reload;
    end else if (advance) begin
      if (cnt_q > ONE) begin
        cnt_d = cnt_q - ONE;
      end else begin
        expire = 1'b1;
        cnt_d  = rsten ? '0 : reload;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse
  import kwd_pkg::*;
#(
  parameter int PW_W = 8,
  parameter int NLINES = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [PW_W-1:0]   width,
  input  kwd_scope_e        scope,
  input  logic [NLINES-1:0] mask,
  output logic [NLINES-1:0] lines
);
  logic [NLINES-1:0] pick;
  logic [NLINES-1:0] lines_q, lines_d;
  logic [PW_W-1:0]   left_q, left_d;

  for (genvar i = 0; i < NLINES; i++) begin : g_pick
    always_comb begin
      unique case (scope)
        SCOPE_ALL: pick[i] = 1'b1;
        SCOPE_CPU: pick[i] = (i == 0);
        default:   pick[i] = mask[i];
      endcase
    end
  end

  always_comb begin
    lines_d = lines_q;
    left_d  = left_q;
    if (fire) begin
      lines_d = pick;
      left_d  = (width == '0) ? PW_W'(1) : width;
    end else if (left_q != '0) begin
      left_d = left_q - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      left_q  <= '0;
    end else begin
      lines_q <= lines_d;
      left_q  <= left_d;
    end
  end

  assign lines = (left_q != '0) ? lines_q : '0;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 8,
  parameter int NLINES = 26,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF,
  parameter logic [PW_W-1:0] WIDTH_RST = 8'd4,
  parameter logic [NLINES-1:0] MASK_RST = 26'h33F_FFF3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1m_en,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic [NLINES-1:0] rst_lines,
  output logic              expired_flag
);
  logic              rst_sync_n;
  logic              key_hit, clr_hit, expire, fire, step;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic              en_q, rsten_q, slow_q, boot_q, flag_q;
  kwd_scope_e        scope_q;
  logic [PW_W-1:0]   width_q;
  logic [NLINES-1:0] mask_q;

  kwd_rst_sync u_sync (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  kwd_regs #(
    .CNT_W(CNT_W), .PW_W(PW_W), .NLINES(NLINES),
    .RELOAD_RST(RELOAD_RST), .WIDTH_RST(WIDTH_RST), .MASK_RST(MASK_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .expire(expire), .key_hit(key_hit), .clr_hit(clr_hit),
    .reload_q(reload_q), .en_q(en_q), .rsten_q(rsten_q), .slow_q(slow_q),
    .scope_q(scope_q), .boot_q(boot_q), .width_q(width_q), .mask_q(mask_q),
    .flag_q(flag_q)
  );

  assign step = slow_q ? tick_1m_en : 1'b1;

  kwd_count #(.CNT_W(CNT_W), .CNT_RST(RELOAD_RST)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .en(en_q), .step(step), .key_hit(key_hit),
    .rsten(rsten_q), .reload(reload_q), .cnt_q(cnt_q), .expire(expire)
  );

  assign fire = expire && rsten_q;

  kwd_pulse #(.PW_W(PW_W), .NLINES(NLINES)) u_pulse (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .width(width_q),
    .scope(scope_q), .mask(mask_q), .lines(rst_lines)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (kwd_addr_e'(bus_addr))
      A_COUNT:  bus_rdata = 32'(cnt_q);
      A_RELOAD: bus_rdata = 32'(reload_q);
      A_CTRL: begin
        bus_rdata[CB_EN]                 = en_q;
        bus_rdata[CB_RSTEN]              = rsten_q;
        bus_rdata[CB_SLOW]               = slow_q;
        bus_rdata[CB_SCOPE+1:CB_SCOPE]   = scope_q;
        bus_rdata[CB_BOOT]               = boot_q;
      end
      A_FLAG:   bus_rdata[0] = flag_q;
      A_WIDTH:  bus_rdata = 32'(width_q);
      A_MASK:   bus_rdata = 32'(mask_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign expired_flag = flag_q;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W = 32,
  parameter int NLINES = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [2:0]        addr,
  input logic [31:0]       wdata,
  input logic              we,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              en,
  input logic              rsten,
  input logic              slow,
  input logic              expire,
  input logic              flag,
  input logic [NLINES-1:0] lines
);
  logic restart_wr;
  assign restart_wr = we && (addr == 3'd2);

  a_r2_key_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_wr && wdata == 32'h0000_4755) |=> (cnt == $past(reload)));

  a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_wr && wdata != 32'h0000_4755 && !en) |=> $stable(cnt));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slow && !tick && !restart_wr) |=> $stable(cnt));

  a_r4_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  a_r4_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rsten) |=> !en);

  a_r4_pulse_needs_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lines) |-> $past(expire && rsten));

  a_r7_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd5 && !expire) |=> !flag);
endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick_1m_en), .addr(bus_addr),
  .wdata(bus_wdata), .we(bus_we), .cnt(cnt_q), .reload(reload_q),
  .en(en_q), .rsten(rsten_q), .slow(slow_q), .expire(expire),
  .flag(flag_q), .lines(rst_lines)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic [25:0] lines;
  logic        flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_1m_en(tick), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata),
    .rst_lines(lines), .expired_flag(flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_cnt;
    logic [31:0] pat;
    rst_n = 1'b0; tick = 1'b0; addr = '0; wdata = '0; we = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);

    // R1 reset state
    rd(3, v); chk("R1 ctrl", v, 32'h0);
    rd(4, v); chk("R1 flag", v, 32'h0);
    chk("R1 lines", {6'b0, lines}, 32'h0);
    rd(1, v); chk("R1 reload", v, 32'h0000_FFFF);
    rd(0, v); chk("R1 counter", v, 32'h0000_FFFF);
    rd(6, v); chk("R1 width", v, 32'd4);
    rd(7, v); chk("R1 mask", v, 32'h033F_FFF3);

    // R10 / R8 map and readback widths
    wr(1, 32'h1234_5678); rd(1, v); chk("R10 reload word", v, 32'h1234_5678);
    wr(6, 32'hFFFF_FF07); rd(6, v); chk("R10 width word", v, 32'h07);
    wr(7, 32'hFFFF_FFFF); rd(7, v); chk("R10 mask word", v, 32'h03FF_FFFF);
    wr(3, 32'hFFFF_FF90); rd(3, v); chk("R8 ctrl bits", v, 32'h90);
    wr(3, 32'h80); rd(3, v); chk("R8 boot bit", v, 32'h80);
    rd(0, v); cycles(10); rd(0, exp_cnt); chk("R8 boot no count", exp_cnt, v);
    wr(3, 32'h0);

    // R2 key handling
    wr(1, 32'd100); wr(2, 32'h0000_4755);
    rd(0, v); chk("R2 key loads", v, 32'd100);
    wr(1, 32'd50);
    foreach (pat[i]) ;
    begin
      logic [31:0] bad [5] = '{32'h0, 32'h4754, 32'h4756, 32'h0001_4755, 32'hFFFF_4755};
      for (int k = 0; k < 5; k++) begin
        wr(2, bad[k]); rd(0, v); chk("R2 bad key ignored", v, 32'd100);
      end
    end
    wr(2, 32'h0000_4755); rd(0, v); chk("R2 key reload new", v, 32'd50);

    // R3 every-clock counting
    wr(3, 32'h1);
    exp_cnt = 32'd50;
    for (int k = 0; k < 20; k++) begin
      cycles(1); exp_cnt--;
      rd(0, v); chk("R3 fast decrement", v, exp_cnt);
    end
    wr(3, 32'h0);
    rd(0, exp_cnt); cycles(8); rd(0, v); chk("R3 disabled hold", v, exp_cnt);

    // R3 tick-gated counting
    wr(1, 32'd100); wr(2, 32'h0000_4755); wr(3, 32'h11);
    pat = 32'hA5C3_1F08; exp_cnt = 32'd100;
    for (int k = 0; k < 32; k++) begin
      tick = pat[k];
      cycles(1);
      if (pat[k]) exp_cnt--;
      rd(0, v); chk("R3 tick decrement", v, exp_cnt);
    end
    tick = 1'b0;
    wr(3, 32'h0);

    // R6 periodic expiry without reset
    wr(1, 32'd5); wr(2, 32'h0000_4755); wr(3, 32'h1);
    cycles(4);
    rd(0, v); chk("R6 count before", v, 32'd1);
    chk("R6 flag before", {31'b0, flag}, 32'd0);
    cycles(1);
    chk("R6 flag after", {31'b0, flag}, 32'd1);
    rd(0, v); chk("R6 reloaded", v, 32'd5);
    rd(3, v); chk("R6 enable kept", v, 32'h1);
    chk("R6 no lines", {6'b0, lines}, 32'h0);
    wr(3, 32'h0);

    // R7 clear with arbitrary values
    wr(5, 32'h0); chk("R7 clear zero", {31'b0, flag}, 32'd0);
    wr(4, 32'h0); rd(4, v); chk("R10 flag word read-only", v, 32'd0);

    // R4 / R5 sweep over scope codes and widths
    for (int mode = 0; mode < 4; mode++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w, first, len;
        logic [25:0] seen, expl;
        w = (wi == 0) ? 0 : (wi == 1) ? 1 : 3;
        wr(7, 32'hF0A5_5A5A); wr(6, w); wr(1, 32'd3);
        wr(2, 32'h0000_4755);
        wr(3, 32'h3 | (mode << 5));
        first = -1; len = 0; seen = '0;
        for (int c = 1; c <= 12; c++) begin
          cycles(1);
          if (lines != '0) begin
            if (first < 0) first = c;
            len++; seen = lines;
          end
        end
        expl = (mode == 1) ? 26'h3FF_FFFF : (mode == 2) ? 26'h1 : 26'h0A5_5A5A;
        chk("R4 pulse start", first, 32'd3);
        chk("R4 pulse length", len, (w == 0) ? 32'd1 : w);
        chk("R5 pulse scope", {6'b0, seen}, {6'b0, expl});
        chk("R4 flag set", {31'b0, flag}, 32'd1);
        rd(3, v); chk("R4 enable cleared", v, 32'h2 | (mode << 5));
        wr(5, 32'hDEAD_BEEF); chk("R7 clear any", {31'b0, flag}, 32'd0);
      end
    end

    // R9 reload 1 start sequence
    begin
      int first;
      wr(6, 2); wr(7, 32'h1); wr(1, 32'd1); wr(2, 32'h0000_4755);
      wr(3, 32'h3);
      first = -1;
      for (int c = 1; c <= 6; c++) begin
        cycles(1);
        if (lines != '0 && first < 0) first = c;
      end
      chk("R9 immediate expiry", first, 32'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule